// File: doc/BRIEF.md
# LCD Subpixel Output Formatter

This block sits between the display-memory read path and the panel data pins. It takes one RGB pixel per handshake and sends its three colour components out one after another, in one of six panel orders chosen by a control field. A data transformation comes after the reordering. It can pass the data through, invert every bit, force all bits low or force all bits high.

A frame-sequential mode emits a single component per pixel instead of three. In this mode the component changes from frame to frame, following the same selected order. One control register, written through a simple write port, sets the order, the data transformation, the readout enable and the DISP pin level. The order and transformation fields are staged and take effect only at the next frame start. The readout enable and DISP level take effect on the next cycle.

While readout is disabled, the block accepts no pixels and holds its data output at zero. It also gates the externally generated shift, line-latch and frame timing strobes to their inactive level.

Top module: `lcd_subpx_fmt`

## Requirements
- R1: The control register bits 7:5 select the component order. The orders are: 000 R,G,B; 001 G,B,R; 010 B,R,G; 101 R,B,G; 110 G,R,B; 111 B,G,R.
- R2: Order codes 011 and 100 produce R,G,B, the same as 000.
- R3: In pixel mode (`fseq_mode`=0) each accepted pixel produces exactly three consecutive `out_valid` beats, starting the cycle after acceptance. `pix_ready` stays low from acceptance until the cycle after the third beat.
- R4: In frame-sequential mode (`fseq_mode`=1) each accepted pixel produces one beat. The first frame start after entering the mode selects the first component of the order. Each later frame start advances to the next component, and the third wraps to the first.
- R5: Register bits 3:2 set the data mode, which is applied after reordering: 00 unchanged, 01 bitwise inverse, 10 all zeros, 11 all ones.
- R6: Only writes to address 0x01 change the control register. Writes to other addresses have no effect.
- R7: Register bit 1 enables readout (`rd_en`). While it is 0, `pix_ready`, `out_valid` and `out_data` are 0, and `lcd_shift`, `lcd_latch` and `lcd_frame` are 0. While it is 1, those three copy `tm_shift`, `tm_latch` and `tm_frame`.
- R8: Register bit 0 drives `disp` (0 low, 1 high) from the cycle after the write, whatever the readout state.
- R9: New order and data-mode values apply only from the next `frame_start` onward. The readout enable applies from the cycle after the write.
- R10: After reset the register is all zero. Readout is off, `disp` is low, and order 000 with mode 00 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| fseq_mode | input | 1 | 1 selects frame-sequential mode |
| pix_valid | input | 1 | Pixel available from memory readout |
| pix_r | input | COMP_W | Red component |
| pix_g | input | COMP_W | Green component |
| pix_b | input | COMP_W | Blue component |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| out_valid | output | 1 | A component beat is on `out_data` |
| out_data | output | COMP_W | Transformed component data |
| rd_en | output | 1 | Display-memory readout enable |
| disp | output | 1 | DISP pin level |
| tm_shift | input | 1 | Shift clock from timing generator |
| tm_latch | input | 1 | Line latch from timing generator |
| tm_frame | input | 1 | Frame signal from timing generator |
| lcd_shift | output | 1 | Gated shift clock |
| lcd_latch | output | 1 | Gated line latch |
| lcd_frame | output | 1 | Gated frame signal |

## Verification
The bench drives all eight order codes through one pixel with distinct component values. A swapped permutation entry would put the wrong component in the wrong beat, and a mishandled undefined code would give a sequence other than R,G,B. It writes a new order and data mode without a frame start and expects the old settings to stay in use. A design that applied settings at once would change the beats one frame early. It stops readout while the timing inputs are held high and offers pixels, where a leaking gate or missing ready qualification would show toggling strobes or beats. It also runs four frames in frame-sequential mode with inversion, where a design that wraps the slot counter wrongly or reverses the transform order would give the wrong component or value.

// File: rtl/lcd_fmt_pkg.sv
package lcd_fmt_pkg;

   typedef enum logic [1:0] {
      COMP_R = 2'd0,
      COMP_G = 2'd1,
      COMP_B = 2'd2
   } comp_e;

   typedef enum logic [1:0] {
      DM_PASS = 2'd0,
      DM_INV  = 2'd1,
      DM_ZERO = 2'd2,
      DM_ONE  = 2'd3
   } dmode_e;

   // Component emitted at position pos (0..2) for a given order code.
   function automatic comp_e order_comp(input logic [2:0] code, input logic [1:0] pos);
      comp_e c0, c1, c2;
      case (code)
         3'b001:  begin c0 = COMP_G; c1 = COMP_B; c2 = COMP_R; end
         3'b010:  begin c0 = COMP_B; c1 = COMP_R; c2 = COMP_G; end
         3'b101:  begin c0 = COMP_R; c1 = COMP_B; c2 = COMP_G; end
         3'b110:  begin c0 = COMP_G; c1 = COMP_R; c2 = COMP_B; end
         3'b111:  begin c0 = COMP_B; c1 = COMP_G; c2 = COMP_R; end
         default: begin c0 = COMP_R; c1 = COMP_G; c2 = COMP_B; end
      endcase
      case (pos)
         2'd0:    return c0;
         2'd1:    return c1;
         default: return c2;
      endcase
   endfunction

endpackage

// File: rtl/lcd_fmt_regs.sv
module lcd_fmt_regs #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              frame_start,
   output logic              rd_on,
   output logic              disp_lvl,
   output logic [2:0]        order_act,
   output logic [1:0]        mode_act
);
   localparam int ORD_LSB  = 5;
   localparam int MODE_LSB = 2;
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

   logic [2:0] order_pend;
   logic [1:0] mode_pend;
   logic       hit;
   logic       unused_wdata;

   assign hit          = we && (addr == HIT_ADDR);
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         order_pend <= '0;
         mode_pend  <= '0;
         rd_on      <= 1'b0;
         disp_lvl   <= 1'b0;
         order_act  <= '0;
         mode_act   <= '0;
      end else begin
         if (hit) begin
            order_pend <= wdata[ORD_LSB+:3];
            mode_pend  <= wdata[MODE_LSB+:2];
            rd_on      <= wdata[1];
            disp_lvl   <= wdata[0];
         end
         if (frame_start) begin
            order_act <= order_pend;
            mode_act  <= mode_pend;
         end
      end
   end
endmodule

// File: rtl/lcd_fmt_seq.sv
module lcd_fmt_seq #(
   parameter int NCOMP = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_on,
   input  logic       fseq,
   input  logic       frame_start,
   input  logic       pix_valid,
   output logic       pix_ready,
   output logic       busy,
   output logic [1:0] comp_pos
);
   localparam logic [1:0] LAST = 2'(NCOMP - 1);

   logic [1:0] beat;
   logic [1:0] slot;
   logic       accept;
   logic       last_beat;

   assign pix_ready = rd_on && !busy;
   assign accept    = pix_valid && pix_ready;
   assign last_beat = fseq || (beat == LAST);
   assign comp_pos  = fseq ? slot : beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         beat <= '0;
      end else if (!rd_on) begin
         busy <= 1'b0;
         beat <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         beat <= '0;
      end else if (busy) begin
         if (last_beat) busy <= 1'b0;
         else           beat <= beat + 2'd1;
      end
   end

   // Frame slot rests on LAST outside frame-sequential mode, so the
   // first frame start in that mode lands on position 0.
   always_ff @(posedge clk) begin
      if (!rst_n || !fseq)  slot <= LAST;
      else if (frame_start) slot <= (slot == LAST) ? 2'd0 : slot + 2'd1;
   end
endmodule

// File: rtl/lcd_fmt_dmode.sv
module lcd_fmt_dmode
   import lcd_fmt_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] din,
   input  dmode_e       mode,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = (mode == DM_PASS) ?  din[i] :
                       (mode == DM_INV)  ? ~din[i] :
                       (mode == DM_ONE);
   end
endmodule

// File: rtl/lcd_subpx_fmt.sv
module lcd_subpx_fmt
   import lcd_fmt_pkg::*;
#(
   parameter int COMP_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              frame_start,
   input  logic              fseq_mode,
   input  logic              pix_valid,
   input  logic [COMP_W-1:0] pix_r,
   input  logic [COMP_W-1:0] pix_g,
   input  logic [COMP_W-1:0] pix_b,
   output logic              pix_ready,
   output logic              out_valid,
   output logic [COMP_W-1:0] out_data,
   output logic              rd_en,
   output logic              disp,
   input  logic              tm_shift,
   input  logic              tm_latch,
   input  logic              tm_frame,
   output logic              lcd_shift,
   output logic              lcd_latch,
   output logic              lcd_frame
);
   localparam int NCOMP = 3;

   if (COMP_W < 1)                       begin : g_bad_comp  $error("COMP_W must be at least 1"); end
   if (DATA_W < 8)                       begin : g_bad_data  $error("DATA_W must be at least 8"); end
   if (ADDR_W < 1 || CTRL_ADDR >= (1 << ADDR_W))
                                         begin : g_bad_addr  $error("CTRL_ADDR does not fit ADDR_W"); end

   logic              rd_on;
   logic              disp_lvl;
   logic [2:0]        order_act;
   logic [1:0]        mode_act;
   logic              busy;
   logic [1:0]        comp_pos;
   logic [COMP_W-1:0] hold_r, hold_g, hold_b;
   logic [COMP_W-1:0] sel_data, dm_data;
   comp_e             comp;

   lcd_fmt_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .frame_start(frame_start), .rd_on(rd_on), .disp_lvl(disp_lvl),
      .order_act(order_act), .mode_act(mode_act)
   );

   lcd_fmt_seq #(.NCOMP(NCOMP)) u_seq (
      .clk(clk), .rst_n(rst_n), .rd_on(rd_on), .fseq(fseq_mode),
      .frame_start(frame_start), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .busy(busy), .comp_pos(comp_pos)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_r <= '0;
         hold_g <= '0;
         hold_b <= '0;
      end else if (pix_valid && pix_ready) begin
         hold_r <= pix_r;
         hold_g <= pix_g;
         hold_b <= pix_b;
      end
   end

   assign comp = order_comp(order_act, comp_pos);

   always_comb begin
      case (comp)
         COMP_R:  sel_data = hold_r;
         COMP_G:  sel_data = hold_g;
         default: sel_data = hold_b;
      endcase
   end

   lcd_fmt_dmode #(.W(COMP_W)) u_dmode (
      .din(sel_data), .mode(dmode_e'(mode_act)), .dout(dm_data)
   );

   assign out_valid = busy && rd_on;
   assign out_data  = out_valid ? dm_data : '0;
   assign rd_en     = rd_on;
   assign disp      = disp_lvl;
   assign lcd_shift = tm_shift && rd_on;
   assign lcd_latch = tm_latch && rd_on;
   assign lcd_frame = tm_frame && rd_on;
endmodule

// File: rtl/lcd_subpx_fmt_chk.sv
module lcd_subpx_fmt_chk #(
   parameter int COMP_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              frame_start,
   input logic              fseq_mode,
   input logic              pix_valid,
   input logic              pix_ready,
   input logic              out_valid,
   input logic [COMP_W-1:0] out_data,
   input logic              rd_en,
   input logic              disp,
   input logic              lcd_shift,
   input logic              lcd_latch,
   input logic              lcd_frame,
   input logic [2:0]        order_act,
   input logic [1:0]        mode_act
);
   assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (!pix_ready && !out_valid && out_data == '0 &&
                  !lcd_shift && !lcd_latch && !lcd_frame));

   assert_disp_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(CTRL_ADDR)) |=> (disp == $past(reg_wdata[0])));

   assert_settings_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(order_act) && $stable(mode_act)));

   assert_beats_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready && !fseq_mode && !reg_we) |=> (out_valid && !pix_ready));

   assert_force_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode_act == 2'b10) |-> (out_data == '0));

   assert_force_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode_act == 2'b11) |-> (out_data == '1));
endmodule

bind lcd_subpx_fmt lcd_subpx_fmt_chk #(
   .COMP_W(COMP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .frame_start(frame_start), .fseq_mode(fseq_mode), .pix_valid(pix_valid),
   .pix_ready(pix_ready), .out_valid(out_valid), .out_data(out_data), .rd_en(rd_en),
   .disp(disp), .lcd_shift(lcd_shift), .lcd_latch(lcd_latch), .lcd_frame(lcd_frame),
   .order_act(order_act), .mode_act(mode_act)
);

// File: tb/tb_lcd_subpx_fmt.sv
module tb_lcd_subpx_fmt;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       frame_start = 1'b0;
   logic       fseq_mode = 1'b0;
   logic       pix_valid = 1'b0;
   logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
   logic       pix_ready, out_valid, rd_en, disp;
   logic [7:0] out_data;
   logic       tm_shift = 1'b1, tm_latch = 1'b1, tm_frame = 1'b1;
   logic       lcd_shift, lcd_latch, lcd_frame;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   always #10 clk = ~clk;

   lcd_subpx_fmt dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .frame_start(frame_start), .fseq_mode(fseq_mode), .pix_valid(pix_valid),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_ready(pix_ready),
      .out_valid(out_valid), .out_data(out_data), .rd_en(rd_en), .disp(disp),
      .tm_shift(tm_shift), .tm_latch(tm_latch), .tm_frame(tm_frame),
      .lcd_shift(lcd_shift), .lcd_latch(lcd_latch), .lcd_frame(lcd_frame)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_comp(input logic [2:0] code, input int pos,
                                           input logic [7:0] r, g, b);
      string s;
      case (code)
         3'd1: s = "GBR";
         3'd2: s = "BRG";
         3'd5: s = "RBG";
         3'd6: s = "GRB";
         3'd7: s = "BGR";
         default: s = "RGB";
      endcase
      if (s[pos] == "R") return r;
      if (s[pos] == "G") return g;
      return b;
   endfunction

   function automatic logic [7:0] exp_mode(input logic [7:0] v, input logic [1:0] m);
      case (m)
         2'd0: return v;
         2'd1: return ~v;
         2'd2: return 8'h00;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic frame();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
   endtask

   // Pixel mode: three beats, ready only after the third.
   task automatic pixel3(input string req, input logic [2:0] code, input logic [1:0] m,
                         input logic [7:0] r, g, b);
      @(negedge clk);
      chk({req, " ready before pixel"}, pix_ready, 1);
      pix_valid = 1'b1; pix_r = r; pix_g = g; pix_b = b;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         pix_valid = 1'b0;
         chk({req, " beat valid"}, out_valid, 1);
         chk({req, " beat data"}, out_data, exp_mode(exp_comp(code, k, r, g, b), m));
         chk({req, " R3 ready low during beats"}, pix_ready, 0);
      end
      @(negedge clk);
      chk({req, " R3 no fourth beat"}, out_valid, 0);
      chk({req, " R3 ready after third beat"}, pix_ready, 1);
   endtask

   task automatic pixel1(input string req, input logic [7:0] expv);
      @(negedge clk);
      pix_valid = 1'b1; pix_r = 8'hA1; pix_g = 8'hB2; pix_b = 8'hC3;
      @(negedge clk);
      pix_valid = 1'b0;
      chk({req, " single beat valid"}, out_valid, 1);
      chk({req, " single beat data"}, out_data, expv);
      @(negedge clk);
      chk({req, " one beat only"}, out_valid, 0);
      chk({req, " ready again"}, pix_ready, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 rd_en", rd_en, 0);
      chk("R10 disp", disp, 0);
      chk("R10 R7 ready", pix_ready, 0);
      chk("R10 R7 out_valid", out_valid, 0);
      chk("R10 R7 gated strobes", {lcd_shift, lcd_latch, lcd_frame}, 0);
   endtask

   task automatic t_orders();
      for (int c = 0; c < 8; c++) begin
         wr(8'h01, {3'(c), 3'b000, 2'b11});
         frame();
         chk("R7 strobes pass when on", {lcd_shift, lcd_latch, lcd_frame}, 3'b111);
         pixel3((c == 3 || c == 4) ? "R2 undefined order" : "R1 order", 3'(c), 2'd0,
                8'h11, 8'h22, 8'h33);
      end
   endtask

   task automatic t_modes();
      for (int m = 1; m < 4; m++) begin
         wr(8'h01, {3'b101, 1'b0, 2'(m), 2'b11});
         frame();
         pixel3("R5 mode after reorder", 3'b101, 2'(m), 8'h5A, 8'h0F, 8'hC3);
      end
   endtask

   task automatic t_deferred();
      wr(8'h01, {3'b111, 1'b0, 2'b00, 2'b11});
      frame();
      wr(8'h01, {3'b001, 1'b0, 2'b01, 2'b11});
      pixel3("R9 old settings before frame", 3'b111, 2'd0, 8'h12, 8'h34, 8'h56);
      frame();
      pixel3("R9 new settings after frame", 3'b001, 2'd1, 8'h12, 8'h34, 8'h56);
   endtask

   task automatic t_other_addr();
      wr(8'h02, 8'h00);
      chk("R6 rd_en unchanged", rd_en, 1);
      chk("R6 disp unchanged", disp, 1);
      frame();
      pixel3("R6 order unchanged", 3'b001, 2'd1, 8'h77, 8'h88, 8'h99);
   endtask

   task automatic t_stop();
      wr(8'h01, 8'b001_0_00_01);
      chk("R8 disp high while stopped", disp, 1);
      chk("R7 rd_en off", rd_en, 0);
      @(negedge clk); pix_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R7 ready held low", pix_ready, 0);
         chk("R7 no beat", out_valid, 0);
         chk("R7 data zero", out_data, 0);
         chk("R7 strobes inactive", {lcd_shift, lcd_latch, lcd_frame}, 0);
      end
      pix_valid = 1'b0;
      wr(8'h01, 8'b000_0_00_10);
      chk("R8 disp low while running", disp, 0);
      chk("R7 strobes resume", {lcd_shift, lcd_latch, lcd_frame}, 3'b111);
      frame();
      pixel3("R7 readout resumed", 3'b000, 2'd0, 8'h01, 8'h02, 8'h03);
   endtask

   task automatic t_fseq();
      wr(8'h01, 8'b110_0_01_11);
      frame();
      @(negedge clk); fseq_mode = 1'b1;
      frame(); pixel1("R4 frame 0 G inverted", ~8'hB2);
      pixel1("R4 same frame keeps G", ~8'hB2);
      frame(); pixel1("R4 frame 1 R", ~8'hA1);
      frame(); pixel1("R4 frame 2 B", ~8'hC3);
      frame(); pixel1("R4 wrap to G", ~8'hB2);
      @(negedge clk); fseq_mode = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_orders();
      t_modes();
      t_deferred();
      t_other_addr();
      t_stop();
      t_fseq();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule